// File: doc/BRIEF.md
# Dual-Accumulator Vector FIR Sequencer

This block runs a 16-tap FIR filter over a stream of signed 32-bit samples. It produces eight adjacent outputs at once. In each active cycle it applies one tap: a single coefficient is broadcast to all eight lanes, and each lane multiplies it by its own sample taken from a two-half sample window. Samples arrive as 8-word beats on a valid/ready handshake. The sixteen coefficients come from a flat coefficient register input that the user holds steady while the filter runs.

The window has two 256-bit halves, a low half and a high half. After a three-beat prime, the block reloads the low half partway through each pass. At the end of each pass it exchanges the two halves. Each pass therefore needs exactly one new beat. A product takes two cycles to reach an accumulator, so a running sum cannot be extended in the next cycle. Even taps therefore go to one accumulator bank and odd taps to another. The two banks are added when the pass ends and the sum is presented as one 8-lane result vector with a single-cycle valid pulse.

Top module: `vfir_dualacc`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: Result vector n, lane i equals the sum over k = 0..15 of c[k] * x[8n+i+k]. Here x[m] is the m-th accepted sample and c[k] occupies `coef` bits [32k+31:32k].
- R3: A beat is accepted on a clock edge where `in_valid` and `in_ready` are both 1. Its word j sits in `in_data` bits [32j+31:32j] and is sample 8b+j of beat b. The first result follows the third beat, and every further beat yields one more result.
- R4: Pass n reads beats n, n+1 and n+2. The third of these is accepted only after taps 0..7 have issued: with a continuous stream it is accepted 9 cycles after the preceding beat. `in_ready` is 0 in every cycle that issues a tap.
- R5: Taps issue one per cycle in the order 0..7 and then 8..15. The first even tap and the first odd tap of a pass overwrite their accumulator bank, and every later tap adds to its bank.
- R6: Even taps and odd taps accumulate into separate banks, and neither bank is written in two consecutive cycles.
- R7: `out_valid` is a one-cycle pulse per result. Lane i of the result is in `out_data` bits [32i+31:32i]. With a continuous input stream, `out_valid` rises 11 cycles after the third beat of the pass is accepted.
- R8: With `in_valid` held at 1, results follow one another every 19 cycles.
- R9: Products and sums wrap modulo 2^32 in two's complement.
- R10: Idle cycles on `in_valid` only delay results and do not change their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample beat present |
| in_ready | output | 1 | Block can take a beat this cycle |
| in_data | input | 256 | Eight 32-bit samples, word 0 oldest |
| coef | input | 512 | Sixteen 32-bit coefficients, tap 0 in low word |
| out_valid | output | 1 | Result vector valid, one cycle |
| out_data | output | 256 | Eight 32-bit results, lane 0 in low word |

## Verification
Sixteen single-tap coefficient sets are run one after another. Each set makes the output a shifted copy of the input, so any fault in window position, half selection or coefficient indexing shows up as a mismatch. An increasing-weight coefficient set keeps the order of taps and the split into even and odd banks from being interchangeable. Random data with large magnitudes exercises wrap-around. A continuous stream pins down the acceptance and result timing, and a stream with random idle gaps shows that stalls do not change the values.

// File: rtl/vfir_pkg.sv
package vfir_pkg;
  parameter int unsigned SMP_W = 32;

  typedef logic [SMP_W-1:0] smp_t;

  typedef enum logic [2:0] {
    ST_FILL0,
    ST_FILL1,
    ST_RUN_LO,
    ST_LOAD,
    ST_RUN_HI,
    ST_DRAIN,
    ST_SUM
  } vfir_state_e;

  // signed multiply keeping the low word (two's complement wrap)
  function automatic smp_t wrap_mul(input smp_t a, input smp_t b);
    logic signed [2*SMP_W-1:0] full;
    full = $signed(a) * $signed(b);
    return full[SMP_W-1:0];
  endfunction

  function automatic smp_t wrap_add(input smp_t a, input smp_t b);
    return a + b;
  endfunction
endpackage

// File: rtl/vfir_window.sv
module vfir_window
  import vfir_pkg::*;
#(
  parameter int unsigned LANES = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load_lo,
  input  logic                         load_hi,
  input  logic                         swap,
  input  logic [LANES*SMP_W-1:0]       din,
  input  logic                         hi_phase,
  input  logic [$clog2(LANES)-1:0]     tap_off,
  output logic [LANES*SMP_W-1:0]       lane_x
);
  localparam int unsigned HALF_W = LANES * SMP_W;
  localparam int unsigned POS_W  = $clog2(2 * LANES);

  logic [HALF_W-1:0] half_lo, half_hi;
  logic [HALF_W-1:0] lead, trail;
  logic [2*HALF_W-1:0] joined;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_lo <= '0;
      half_hi <= '0;
    end else if (swap) begin
      half_lo <= half_hi;
      half_hi <= half_lo;
    end else begin
      if (load_lo) half_lo <= din;
      if (load_hi) half_hi <= din;
    end
  end

  // in the second half of a pass the reloaded low half holds the newest beat
  always_comb begin
    lead   = hi_phase ? half_hi : half_lo;
    trail  = hi_phase ? half_lo : half_hi;
    joined = {trail, lead};
  end

  for (genvar i = 0; i < LANES; i++) begin : g_pick
    logic [POS_W-1:0] pos;
    assign pos = POS_W'(i) + POS_W'(tap_off);
    assign lane_x[i*SMP_W +: SMP_W] = joined[pos*SMP_W +: SMP_W];
  end
endmodule

// File: rtl/vfir_lane_mul.sv
module vfir_lane_mul
  import vfir_pkg::*;
#(
  parameter int unsigned LANES = 8
) (
  input  logic [LANES*SMP_W-1:0] lane_x,
  input  smp_t                   weight,
  output logic [LANES*SMP_W-1:0] prod
);
  for (genvar i = 0; i < LANES; i++) begin : g_mul
    assign prod[i*SMP_W +: SMP_W] = wrap_mul(lane_x[i*SMP_W +: SMP_W], weight);
  end
endmodule

// File: rtl/vfir_acc_pair.sv
module vfir_acc_pair
  import vfir_pkg::*;
#(
  parameter int unsigned LANES = 8,
  parameter int unsigned TAP_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   issue,
  input  logic [TAP_W-1:0]       tap,
  input  logic [LANES*SMP_W-1:0] prod_in,
  output logic [LANES*SMP_W-1:0] acc_even,
  output logic [LANES*SMP_W-1:0] acc_odd,
  output logic                   wr_even,
  output logic                   wr_odd
);
  logic                   vld_q;
  logic                   bank_q;
  logic                   first_q;
  logic [LANES*SMP_W-1:0] prod_q;

  // product stage: the accumulator sees tap k one cycle after it issues
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      bank_q  <= 1'b0;
      first_q <= 1'b0;
      prod_q  <= '0;
    end else begin
      vld_q <= issue;
      if (issue) begin
        prod_q  <= prod_in;
        bank_q  <= tap[0];
        first_q <= (tap[TAP_W-1:1] == '0);
      end
    end
  end

  assign wr_even = vld_q && !bank_q;
  assign wr_odd  = vld_q && bank_q;

  for (genvar i = 0; i < LANES; i++) begin : g_acc
    smp_t p;
    assign p = prod_q[i*SMP_W +: SMP_W];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        acc_even[i*SMP_W +: SMP_W] <= '0;
        acc_odd[i*SMP_W +: SMP_W]  <= '0;
      end else begin
        if (wr_even)
          acc_even[i*SMP_W +: SMP_W] <= first_q ? p : wrap_add(acc_even[i*SMP_W +: SMP_W], p);
        if (wr_odd)
          acc_odd[i*SMP_W +: SMP_W]  <= first_q ? p : wrap_add(acc_odd[i*SMP_W +: SMP_W], p);
      end
    end
  end
endmodule

// File: rtl/vfir_dualacc.sv
module vfir_dualacc
  import vfir_pkg::*;
#(
  parameter int unsigned LANES = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [LANES*SMP_W-1:0]       in_data,
  input  logic [2*LANES*SMP_W-1:0]     coef,
  output logic                         out_valid,
  output logic [LANES*SMP_W-1:0]       out_data
);
  localparam int unsigned TAPS  = 2 * LANES;
  localparam int unsigned TAP_W = $clog2(TAPS);
  localparam int unsigned OFF_W = $clog2(LANES);

  vfir_state_e state_q, state_d;
  logic [TAP_W-1:0] tap_idx;
  logic             tap_go;
  logic             mid_load;
  logic             accept;
  logic             load_lo, load_hi, swap;
  logic             wr_even, wr_odd;
  smp_t             weight;
  logic [LANES*SMP_W-1:0] lane_x, prod, acc_even, acc_odd, sum_vec;
  logic [LANES*SMP_W-1:0] res_q;
  logic             res_vld_q;

  assign in_ready = (state_q == ST_FILL0) || (state_q == ST_FILL1) || (state_q == ST_LOAD);
  assign accept   = in_valid && in_ready;
  assign tap_go   = (state_q == ST_RUN_LO) || (state_q == ST_RUN_HI);
  assign mid_load = (state_q == ST_LOAD) && in_valid;
  assign load_lo  = accept && (state_q != ST_FILL1);
  assign load_hi  = accept && (state_q == ST_FILL1);
  assign swap     = (state_q == ST_SUM);
  assign weight   = coef[tap_idx*SMP_W +: SMP_W];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FILL0:  if (in_valid) state_d = ST_FILL1;
      ST_FILL1:  if (in_valid) state_d = ST_RUN_LO;
      ST_RUN_LO: if (tap_idx == TAP_W'(LANES - 1)) state_d = ST_LOAD;
      ST_LOAD:   if (in_valid) state_d = ST_RUN_HI;
      ST_RUN_HI: if (tap_idx == TAP_W'(TAPS - 1)) state_d = ST_DRAIN;
      ST_DRAIN:  state_d = ST_SUM;
      ST_SUM:    state_d = ST_RUN_LO;
      default:   state_d = ST_FILL0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_FILL0;
      tap_idx <= '0;
    end else begin
      state_q <= state_d;
      if (tap_go) tap_idx <= tap_idx + 1'b1;
    end
  end

  vfir_window #(.LANES(LANES)) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_lo  (load_lo),
    .load_hi  (load_hi),
    .swap     (swap),
    .din      (in_data),
    .hi_phase (state_q == ST_RUN_HI),
    .tap_off  (tap_idx[OFF_W-1:0]),
    .lane_x   (lane_x)
  );

  vfir_lane_mul #(.LANES(LANES)) u_mul (
    .lane_x (lane_x),
    .weight (weight),
    .prod   (prod)
  );

  vfir_acc_pair #(.LANES(LANES), .TAP_W(TAP_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue    (tap_go),
    .tap      (tap_idx),
    .prod_in  (prod),
    .acc_even (acc_even),
    .acc_odd  (acc_odd),
    .wr_even  (wr_even),
    .wr_odd   (wr_odd)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_sum
    assign sum_vec[i*SMP_W +: SMP_W] =
      wrap_add(acc_even[i*SMP_W +: SMP_W], acc_odd[i*SMP_W +: SMP_W]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q     <= '0;
      res_vld_q <= 1'b0;
    end else begin
      res_vld_q <= (state_q == ST_SUM);
      if (state_q == ST_SUM) res_q <= sum_vec;
    end
  end

  assign out_valid = res_vld_q;
  assign out_data  = res_q;
endmodule

// File: rtl/vfir_dualacc_chk.sv
module vfir_dualacc_chk #(
  parameter int unsigned LANES = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          in_ready,
  input logic                          out_valid,
  input logic                          tap_go,
  input logic [$clog2(2*LANES)-1:0]    tap_idx,
  input logic                          mid_load,
  input logic                          wr_even,
  input logic                          wr_odd
);
  assert_even_spaced_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_even |=> !wr_even);

  assert_odd_spaced_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_odd |=> !wr_odd);

  assert_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_tap_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_go && tap_idx != '0 && tap_idx != LANES) |->
      ($past(tap_go) && (32'(tap_idx) == 32'($past(tap_idx)) + 1)));

  assert_reload_mid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mid_load |=> (tap_go && tap_idx == LANES));

  assert_no_ready_on_tap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tap_go |-> !in_ready);
endmodule

bind vfir_dualacc vfir_dualacc_chk #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .tap_go    (tap_go),
  .tap_idx   (tap_idx),
  .mid_load  (mid_load),
  .wr_even   (wr_even),
  .wr_odd    (wr_odd)
);

// File: tb/vfir_dualacc_bench.sv
module vfir_dualacc_bench;
  localparam int LANES      = 8;
  localparam int W          = 32;
  localparam int TAPS       = 2 * LANES;
  localparam int CLK_PERIOD = 10;
  localparam int MAXB       = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [LANES*W-1:0] in_data = '0;
  logic [TAPS*W-1:0]  coef = '0;
  logic out_valid;
  logic [LANES*W-1:0] out_data;

  vfir_dualacc #(.LANES(LANES)) u_vfir_dualacc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .coef(coef), .out_valid(out_valid), .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] smp [0:MAXB*LANES-1];
  logic [W-1:0] cf  [0:TAPS-1];
  logic [LANES*W-1:0] got [0:MAXB];
  int got_cyc [0:MAXB];
  int acc_cyc [0:MAXB];
  int ngot = 0;

  always @(negedge clk) begin
    if (!rst_n) ngot = 0;
    else if (out_valid && ngot <= MAXB) begin
      got[ngot] = out_data;
      got_cyc[ngot] = cyc;
      ngot++;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog R3 actual=timeout expected=completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [W-1:0] ref_y(int base);
    longint s = 0;
    for (int k = 0; k < TAPS; k++)
      s += longint'($signed(cf[k])) * longint'($signed(smp[base + k]));
    return s[W-1:0];
  endfunction

  task automatic check_int(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    in_valid = 1'b0;
    rst_n = 1'b0;
    for (int k = 0; k < TAPS; k++) coef[k*W +: W] = cf[k];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(int nbeats, bit gaps);
    for (int b = 0; b < nbeats; b++) begin
      if (gaps) begin
        int idle = $urandom_range(0, 3);
        in_valid = 1'b0;
        repeat (idle) @(negedge clk);
      end
      for (int j = 0; j < LANES; j++) in_data[j*W +: W] = smp[b*LANES + j];
      in_valid = 1'b1;
      forever begin
        #1;
        if (in_ready) begin
          acc_cyc[b] = cyc;
          @(negedge clk);
          break;
        end
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
  endtask

  task automatic run_and_check(string tag, int nbeats, bit gaps);
    int nout = nbeats - 2;
    int guard = 0;
    do_reset();
    send(nbeats, gaps);
    while (ngot < nout && guard < 60 * nout) begin
      @(negedge clk);
      guard++;
    end
    repeat (25) @(negedge clk);
    check_int({tag, " R3 R7 result count"}, ngot, nout);
    for (int n = 0; n < nout && n < ngot; n++) begin
      logic [LANES*W-1:0] exp_v;
      for (int i = 0; i < LANES; i++) exp_v[i*W +: W] = ref_y(n*LANES + i);
      checks++;
      if (got[n] !== exp_v) begin
        errors++;
        $display("FAIL %s R2 result %0d actual=%h expected=%h", tag, n, got[n], exp_v);
      end
    end
  endtask

  initial begin
    for (int k = 0; k < TAPS; k++) cf[k] = '0;
    do_reset();
    #1;
    check_int("R1 in_ready after reset", in_ready, 1);
    check_int("R1 out_valid after reset", out_valid, 0);

    // single-tap sweep: output is the input shifted by the tap index
    for (int t = 0; t < TAPS; t++) begin
      for (int k = 0; k < TAPS; k++) cf[k] = (k == t) ? 32'd1 : 32'd0;
      for (int m = 0; m < MAXB*LANES; m++) smp[m] = 32'(m * 3 + 5);
      run_and_check($sformatf("R2 R4 impulse tap %0d", t), 4, 1'b0);
    end

    // increasing weights: order of taps and bank split matter (R5 R6)
    for (int k = 0; k < TAPS; k++) cf[k] = 32'(k + 1);
    for (int m = 0; m < MAXB*LANES; m++) smp[m] = 32'(m * m - 40);
    run_and_check("R5 R6 ramp weights", 8, 1'b0);
    check_int("R4 third beat spacing", acc_cyc[2] - acc_cyc[1], 9);
    check_int("R7 first result latency", got_cyc[0] - acc_cyc[2], 11);
    for (int n = 1; n < 6; n++)
      check_int("R8 result spacing", got_cyc[n] - got_cyc[n-1], 19);

    // large random values force wrap-around (R9)
    for (int k = 0; k < TAPS; k++) cf[k] = $urandom | 32'h4000_0000;
    for (int m = 0; m < MAXB*LANES; m++) smp[m] = $urandom | 32'h7000_0000;
    run_and_check("R9 wrap", 6, 1'b0);

    // random data with idle gaps on the input (R10)
    for (int k = 0; k < TAPS; k++) cf[k] = $urandom_range(0, 2000) - 1000;
    for (int m = 0; m < MAXB*LANES; m++) smp[m] = $urandom;
    run_and_check("R10 gaps", MAXB, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule